// File: doc/BRIEF.md
# Serial EEPROM command sequencer

This block sits behind a byte-level SPI client shifter and turns framed traffic into operations on a byte-wide storage array. The shifter hands it each received byte together with the byte's position in the frame. It also signals the end of a frame (chip select rising), and a flag that says whether that end fell exactly on a byte boundary. The sequencer takes the first byte as an opcode and the next three as a 24-bit address. From these it runs sequential reads, page-buffered writes, page/sector/chip erase requests, deep power-down, and a signature readout.

The array is modelled as a synchronous RAM with a one-cycle read latency and a bulk-erase request. The non-volatile programming time is modelled as a busy counter in system clocks. Whether a modifying command may proceed is decided by a separate protection block. The sequencer shows that block the command kind and the target address, and it obeys a single allow input.

Outgoing bytes use a valid/ready stream. `tx_valid` with `tx_data` is held until the shifter takes the byte with `tx_ready`, and the byte may wait any number of cycles. The receive side carries no back-pressure, because a serial clock cannot be stalled: a byte on `rx_valid` is taken in the cycle it appears.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: A frame with opcode 0x03 presents the array byte at the 17-bit address on the stream two clock edges after its fourth byte. The address is the low 17 bits of the 24-bit value sent MSB first, and its top 7 bits are ignored.
- R2: After each byte taken with `tx_ready`, the read pointer advances by one and wraps from 0x1FFFF to 0x00000. `tx_valid` is low for one cycle and then returns with the next byte.
- R3: Opcode 0x02 stages data bytes from the fifth byte on, starting at the column given by address bits 7:0. The column wraps within the 256-byte page, and on commit only the staged columns are written, a later byte replacing an earlier one.
- R4: A write commits only at an aligned frame end after at least 5 complete bytes. Any other frame end discards the staged data.
- R5: Page erase (0x42) and sector erase (0xD8) commit only at an aligned frame end after exactly 4 bytes. Chip erase (0xC7) commits only at an aligned end after exactly 1 byte. Erased bytes read 0xFF. `mem_span` is 0 for a page, 1 for a 32 KB sector (address bits 16:15) and 2 for the whole chip.
- R6: A write or erase that would otherwise commit does nothing while `prot_ok` is low. `chk_kind` is 0 for a write, 1 for page, 2 for sector and 3 for chip erase, and `chk_addr` is the frame's 17-bit address.
- R7: A commit raises `busy_start` for one cycle and `busy` for exactly WR_CYC cycles (write, page erase) or ER_CYC cycles (sector, chip erase). Both rise one edge after the frame-end cycle. WR_CYC must exceed 257.
- R8: While `busy` is high, reads, signature reads, writes, erases and power-down entry are ignored.
- R9: Opcode 0xB9 enters power-down (`pd_active`) only at an aligned frame end after exactly 1 byte. While in power-down, every opcode except 0xAB is ignored.
- R10: Opcode 0xAB followed by 3 dummy bytes presents the signature 0x29, which stays valid and repeats for every take. Any frame end after at least one byte of 0xAB leaves power-down.
- R11: `tx_valid` and `tx_data` hold while the byte is not taken, and `tx_valid` drops one edge after a frame end.
- R12: After reset, `tx_valid`, `busy`, `busy_start`, `pd_active`, `mem_re`, `mem_we` and `mem_erase` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_idx | input | IDX_W | Position of the byte in the frame, saturating |
| frm_end | input | 1 | Chip select rose (one-cycle pulse) |
| frm_aligned | input | 1 | The frame end fell on a byte boundary |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Shifter takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| chk_kind | output | 2 | Kind of the pending modifying command |
| chk_addr | output | ADDR_W | Target address shown to the protection block |
| prot_ok | input | 1 | Protection block allows the command |
| mem_re | output | 1 | Array read request |
| mem_we | output | 1 | Array byte write |
| mem_erase | output | 1 | Array bulk erase request |
| mem_span | output | 2 | Erase extent |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 8 | Array write byte |
| mem_rdata | input | 8 | Array read byte, valid the cycle after `mem_re` |
| busy_start | output | 1 | Busy timer started |
| busy | output | 1 | Internal write cycle in progress |
| pd_active | output | 1 | Deep power-down state |

## Verification
A read byte is due two edges after the fourth header byte. After each take it is due again two edges later, with one low cycle of `tx_valid` in between. `busy`, `busy_start` and `pd_active` change one edge after the frame-end cycle, and `busy` then lasts its exact cycle count. The bench drives inputs on the falling edge and lets a behavioural model advance on the rising edge. It compares every output at the following falling edge, so each result is checked in the cycle it is due and not near it. Discarded writes and ignored commands are shown through `busy` staying low and through later reads of the addresses they would have changed.

// File: rtl/ees_pkg.sv
package ees_pkg;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_PGERS = 8'h42;
  localparam logic [7:0] OPC_SCERS = 8'hD8;
  localparam logic [7:0] OPC_CHERS = 8'hC7;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;

  typedef enum logic [1:0] {SPAN_PAGE = 2'd0, SPAN_SECTOR = 2'd1, SPAN_CHIP = 2'd2} span_e;
  typedef enum logic [1:0] {KIND_WRITE = 2'd0, KIND_PAGE = 2'd1, KIND_SECT = 2'd2, KIND_CHIP = 2'd3} kind_e;
endpackage

// File: rtl/ees_hdr.sv
module ees_hdr #(
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              frm_end,
  output logic [7:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W:0]    nbytes_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_o     <= 8'h00;
      sh_q     <= '0;
      nbytes_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (frm_end) begin
        op_o     <= 8'h00;
        nbytes_o <= '0;
      end else if (rx_valid) begin
        if (rx_idx == '0) op_o <= rx_data;
        else if (rx_idx <= IDX_W'(3)) sh_q <= ADDR_W'({sh_q, rx_data});
        if (rx_idx == IDX_W'(3)) done_o <= 1'b1;
        nbytes_o <= {1'b0, rx_idx} + (IDX_W+1)'(1);
      end
    end
  end

  assign addr_o = sh_q;
endmodule

// File: rtl/ees_busy.sv
module ees_busy #(
  parameter int WR_CYC = 300,
  parameter int ER_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic start_o
);
  localparam int MAXC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= start;
      if (start) cnt_q <= long_sel ? CW'(ER_CYC) : CW'(WR_CYC);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  a_r7_rise_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start_o);
endmodule

// File: rtl/ees_pagebuf.sv
module ees_pagebuf #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     col_load,
  input  logic [PAGE_W-1:0]        col_init,
  input  logic                     store,
  input  logic [7:0]               store_data,
  input  logic                     commit,
  input  logic                     drop,
  input  logic [ADDR_W-PAGE_W-1:0] base,
  output logic                     we,
  output logic [ADDR_W-1:0]        waddr,
  output logic [7:0]               wdata,
  output logic                     sweeping
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]               data_q [PAGE];
  logic                     flg_q  [PAGE];
  logic [PAGE_W-1:0]        col_q, sw_idx;
  logic [ADDR_W-PAGE_W-1:0] pg_q;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (store && col_q == PAGE_W'(g)) data_q[g] <= store_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[g] <= 1'b0;
      else if (store && col_q == PAGE_W'(g)) flg_q[g] <= 1'b1;
      else if (drop || (sweeping && sw_idx == PAGE_W'(g))) flg_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      sw_idx   <= '0;
      pg_q     <= '0;
      sweeping <= 1'b0;
    end else begin
      if (col_load) col_q <= col_init;
      else if (store) col_q <= col_q + 1'b1;
      if (commit) begin
        sweeping <= 1'b1;
        sw_idx   <= '0;
        pg_q     <= base;
      end else if (sweeping) begin
        sw_idx <= sw_idx + 1'b1;
        if (sw_idx == '1) sweeping <= 1'b0;
      end
    end
  end

  assign we    = sweeping && flg_q[sw_idx];
  assign waddr = {pg_q, sw_idx};
  assign wdata = data_q[sw_idx];

  a_r3_no_store_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !store);
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq #(
  parameter int         IDX_W  = 10,
  parameter int         ADDR_W = 17,
  parameter int         PAGE_W = 8,
  parameter int         WR_CYC = 300,
  parameter int         ER_CYC = 500,
  parameter logic [7:0] SIG    = 8'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              frm_end,
  input  logic              frm_aligned,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [1:0]        chk_kind,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              prot_ok,
  output logic              mem_re,
  output logic              mem_we,
  output logic              mem_erase,
  output logic [1:0]        mem_span,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy_start,
  output logic              busy,
  output logic              pd_active
);
  import ees_pkg::*;

  logic [7:0]        op;
  logic [ADDR_W-1:0] hdr_addr;
  logic [IDX_W:0]    nb;
  logic              hdr_done;

  ees_hdr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_idx(rx_idx), .frm_end(frm_end), .op_o(op), .addr_o(hdr_addr),
    .nbytes_o(nb), .done_o(hdr_done));

  logic idle_ok, aligned_ok;
  logic cm_write, cm_page, cm_sect, cm_chip, cm_any;
  assign idle_ok    = !busy && !pd_active;
  assign aligned_ok = frm_end && frm_aligned && idle_ok && prot_ok;
  assign cm_write   = aligned_ok && op == OPC_WRITE && nb >= (IDX_W+1)'(5);
  assign cm_page    = aligned_ok && op == OPC_PGERS && nb == (IDX_W+1)'(4);
  assign cm_sect    = aligned_ok && op == OPC_SCERS && nb == (IDX_W+1)'(4);
  assign cm_chip    = aligned_ok && op == OPC_CHERS && nb == (IDX_W+1)'(1);
  assign cm_any     = cm_write | cm_page | cm_sect | cm_chip;

  always_comb begin
    case (op)
      OPC_PGERS: chk_kind = KIND_PAGE;
      OPC_SCERS: chk_kind = KIND_SECT;
      OPC_CHERS: chk_kind = KIND_CHIP;
      default:   chk_kind = KIND_WRITE;
    endcase
  end
  assign chk_addr = hdr_addr;

  ees_busy #(.WR_CYC(WR_CYC), .ER_CYC(ER_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(cm_any), .long_sel(cm_sect | cm_chip),
    .busy(busy), .start_o(busy_start));

  // page staging and commit sweep
  logic              pb_we, pb_sweep, pb_store, pb_drop;
  logic [ADDR_W-1:0] pb_addr;
  assign pb_store = rx_valid && op == OPC_WRITE && rx_idx >= IDX_W'(4) && idle_ok;
  assign pb_drop  = frm_end && !cm_write && !pb_sweep;

  ees_pagebuf #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .col_load(rx_valid && rx_idx == IDX_W'(3)),
    .col_init(rx_data[PAGE_W-1:0]), .store(pb_store), .store_data(rx_data),
    .commit(cm_write), .drop(pb_drop), .base(hdr_addr[ADDR_W-1:PAGE_W]),
    .we(pb_we), .waddr(pb_addr), .wdata(mem_wdata), .sweeping(pb_sweep));

  // erase request register
  logic              ers_q;
  logic [1:0]        span_q;
  logic [ADDR_W-1:0] ers_addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ers_q      <= 1'b0;
      span_q     <= SPAN_PAGE;
      ers_addr_q <= '0;
    end else begin
      ers_q <= cm_page | cm_sect | cm_chip;
      if (cm_page | cm_sect | cm_chip) begin
        span_q     <= cm_chip ? SPAN_CHIP : (cm_sect ? SPAN_SECTOR : SPAN_PAGE);
        ers_addr_q <= hdr_addr;
      end
    end
  end

  // read stream and signature
  logic              txv_q, sig_q, refetch_q, rd_start, sig_start;
  logic [ADDR_W-1:0] ptr_q;
  assign rd_start  = hdr_done && op == OPC_READ && idle_ok;
  assign sig_start = hdr_done && op == OPC_WAKE && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q     <= 1'b0;
      sig_q     <= 1'b0;
      refetch_q <= 1'b0;
      ptr_q     <= '0;
    end else if (frm_end) begin
      txv_q     <= 1'b0;
      sig_q     <= 1'b0;
      refetch_q <= 1'b0;
    end else if (rd_start) begin
      ptr_q <= hdr_addr;
      txv_q <= 1'b1;
    end else if (sig_start) begin
      sig_q <= 1'b1;
      txv_q <= 1'b1;
    end else if (txv_q && tx_ready && !sig_q) begin
      ptr_q     <= ptr_q + 1'b1;
      txv_q     <= 1'b0;
      refetch_q <= 1'b1;
    end else if (refetch_q) begin
      refetch_q <= 1'b0;
      txv_q     <= 1'b1;
    end
  end

  // deep power-down state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_active <= 1'b0;
    else if (frm_end) begin
      if (op == OPC_SLEEP && nb == (IDX_W+1)'(1) && frm_aligned && idle_ok) pd_active <= 1'b1;
      else if (op == OPC_WAKE && nb != '0) pd_active <= 1'b0;
    end
  end

  assign tx_valid  = txv_q;
  assign tx_data   = sig_q ? SIG : mem_rdata;
  assign mem_re    = rd_start | refetch_q;
  assign mem_we    = pb_we;
  assign mem_erase = ers_q;
  assign mem_span  = span_q;
  assign mem_addr  = pb_sweep ? pb_addr : (ers_q ? ers_addr_q : (rd_start ? hdr_addr : ptr_q));

  a_r8_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_re);
  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !(mem_re || mem_we || mem_erase));
  a_r4_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r5_erase_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |-> busy);
  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> busy);
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !frm_end) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/eeprom_cmd_seq_tb_top.sv
module eeprom_cmd_seq_tb_top;
  localparam int IDX_W  = 10;
  localparam int ADDR_W = 17;
  localparam int WR_CYC = 300;
  localparam int ER_CYC = 500;
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, frm_end = 1'b0, frm_aligned = 1'b0, tx_ready = 1'b0, prot_ok = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic [IDX_W-1:0] rx_idx = '0;
  logic tx_valid, mem_re, mem_we, mem_erase, busy_start, busy, pd_active;
  logic [7:0] tx_data, mem_wdata;
  logic [7:0] mem_rdata = 8'hFF;
  logic [1:0] chk_kind, mem_span;
  logic [ADDR_W-1:0] chk_addr, mem_addr;

  always #2 clk = ~clk;

  eeprom_cmd_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .ER_CYC(ER_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx),
    .frm_end(frm_end), .frm_aligned(frm_aligned), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .chk_kind(chk_kind), .chk_addr(chk_addr), .prot_ok(prot_ok),
    .mem_re(mem_re), .mem_we(mem_we), .mem_erase(mem_erase), .mem_span(mem_span),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy_start(busy_start), .busy(busy), .pd_active(pd_active));

  // array model attached to the memory port
  logic [7:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_erase) begin
      if (mem_span == 2'd2) ram.delete();
      else if (mem_span == 2'd1) for (int i = 0; i < 32768; i++) ram.delete((int'(mem_addr) & 'h18000) + i);
      else for (int i = 0; i < 256; i++) ram.delete((int'(mem_addr) & 'h1FF00) + i);
    end
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'hFF;
  end

  // behavioural reference model
  int mdl [int];
  int wq_c[$], wq_d[$];
  int m_busy, m_op, m_nb, m_addr, m_ptr, m_col;
  bit m_bs, m_pd, m_txv, m_sig, m_fetch, m_hd, bp, idle, al;

  function automatic int mrd(input int a);
    return mdl.exists(a) ? mdl[a] : 'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_op = 0; m_nb = 0; m_addr = 0; m_ptr = 0; m_col = 0;
      m_bs = 0; m_pd = 0; m_txv = 0; m_sig = 0; m_fetch = 0; m_hd = 0;
      wq_c.delete(); wq_d.delete();
    end else begin
      bp = (m_busy > 0);
      idle = !bp && !m_pd;
      m_bs = 0;
      if (m_busy > 0) m_busy--;
      if (frm_end) begin m_txv = 0; m_sig = 0; m_fetch = 0; end
      else if (m_hd && m_op == 'h03 && idle) begin m_ptr = m_addr & 'h1FFFF; m_txv = 1; end
      else if (m_hd && m_op == 'hAB && !bp) begin m_sig = 1; m_txv = 1; end
      else if (m_txv && tx_ready && !m_sig) begin m_ptr = (m_ptr + 1) & 'h1FFFF; m_txv = 0; m_fetch = 1; end
      else if (m_fetch) begin m_fetch = 0; m_txv = 1; end
      m_hd = 0;
      if (rx_valid) begin
        m_nb = int'(rx_idx) + 1;
        if (rx_idx == 0) m_op = int'(rx_data);
        else if (rx_idx <= 3) m_addr = ((m_addr << 8) | int'(rx_data)) & 'hFFFFFF;
        if (rx_idx == 3) begin m_hd = 1; m_col = int'(rx_data); end
        if (rx_idx >= 4 && m_op == 'h02 && idle) begin
          wq_c.push_back(m_col); wq_d.push_back(int'(rx_data));
          m_col = (m_col + 1) & 'hFF;
        end
      end
      if (frm_end) begin
        al = frm_aligned && idle && prot_ok;
        if (al && m_op == 'h02 && m_nb >= 5) begin
          foreach (wq_c[i]) mdl[(m_addr & 'h1FF00) | wq_c[i]] = wq_d[i];
          m_busy = WR_CYC; m_bs = 1;
        end else if (al && m_op == 'h42 && m_nb == 4) begin
          for (int i = 0; i < 256; i++) mdl.delete((m_addr & 'h1FF00) + i);
          m_busy = WR_CYC; m_bs = 1;
        end else if (al && m_op == 'hD8 && m_nb == 4) begin
          for (int i = 0; i < 32768; i++) mdl.delete((m_addr & 'h18000) + i);
          m_busy = ER_CYC; m_bs = 1;
        end else if (al && m_op == 'hC7 && m_nb == 1) begin
          mdl.delete();
          m_busy = ER_CYC; m_bs = 1;
        end
        if (m_op == 'hB9 && m_nb == 1 && frm_aligned && idle) m_pd = 1;
        else if (m_op == 'hAB && m_nb >= 1) m_pd = 0;
        wq_c.delete(); wq_d.delete();
        m_op = 0; m_nb = 0;
      end
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R12";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == (m_busy > 0), "busy", int'(busy), int'(m_busy > 0));
      chk(busy_start == m_bs, "busy_start", int'(busy_start), int'(m_bs));
      chk(pd_active == m_pd, "pd_active", int'(pd_active), int'(m_pd));
      chk(tx_valid == m_txv, "tx_valid", int'(tx_valid), int'(m_txv));
      if (m_txv && tx_valid)
        chk(int'(tx_data) == (m_sig ? 'h29 : mrd(m_ptr)), "tx_data", int'(tx_data),
            m_sig ? 'h29 : mrd(m_ptr));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic send(input int b, input int idx);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(b);
    rx_idx = IDX_W'((idx > IDX_MAX) ? IDX_MAX : idx);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic fend(input bit aligned);
    @(negedge clk);
    frm_end = 1'b1; frm_aligned = aligned;
    @(negedge clk);
    frm_end = 1'b0; frm_aligned = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hdr(input int op, input int a24);
    send(op, 0); send((a24 >> 16) & 'hFF, 1); send((a24 >> 8) & 'hFF, 2); send(a24 & 'hFF, 3);
  endtask

  task automatic pull(input int hold);
    int t;
    t = 0;
    while (!tx_valid && t < 20) begin @(negedge clk); t++; end
    repeat (hold) @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R12";
    chk(!tx_valid && !busy && !busy_start && !pd_active, "reset outputs", int'(tx_valid | busy | pd_active), 0);
    chk(!mem_re && !mem_we && !mem_erase, "reset array port", int'(mem_re | mem_we | mem_erase), 0);

    tag = "R3";   // wrapping page write at column FE, junk in top address bits
    hdr('h02, 'hFE23FE); send('hAA, 4); send('hBB, 5); send('hCC, 6);
    tag = "R6"; chk(chk_kind == 2'd0 && chk_addr == 17'h023FE, "chk_kind/addr", int'(chk_addr), 'h023FE);
    tag = "R3"; fend(1);
    tag = "R7"; wait_idle();

    tag = "R1"; hdr('h03, 'h8023FE); pull(0);
    tag = "R11"; pull(3);
    tag = "R2"; pull(0); fend(1);
    tag = "R3"; hdr('h03, 'h002300); pull(0); fend(1);

    tag = "R4";   // unaligned end, header-only write, then data absent
    hdr('h02, 'h001000); send('h11, 4); send('h22, 5); fend(0);
    hdr('h02, 'h001000); fend(1);
    hdr('h03, 'h001000); pull(0); fend(1);

    tag = "R6"; prot_ok = 1'b0;
    hdr('h02, 'h001000); send('h33, 4); fend(1);
    prot_ok = 1'b1;
    hdr('h03, 'h001000); pull(0); fend(1);

    tag = "R8"; hdr('h02, 'h01FFFF); send('h5A, 4); fend(1);
    hdr('h03, 'h01FFFF); repeat (6) @(negedge clk); fend(1);
    hdr('h02, 'h000000); send('h77, 4); fend(1);
    hdr('hAB, 'h000000); repeat (4) @(negedge clk); fend(1);
    wait_idle();

    tag = "R2"; hdr('h03, 'h01FFFF); pull(0); pull(0); pull(0); fend(1);

    tag = "R5"; hdr('h42, 'h002355); fend(1); wait_idle();
    hdr('h03, 'h0023FE); pull(0); fend(1);
    hdr('hD8, 'h018001); send('h00, 4); fend(1);
    hdr('h03, 'h01FFFF); pull(0); fend(1);
    hdr('hD8, 'h018001); fend(1); wait_idle();
    hdr('h03, 'h01FFFF); pull(0); fend(1);
    hdr('h02, 'h000010); send('h99, 4); fend(1); wait_idle();
    send('hC7, 0); send('h00, 1); fend(1);
    hdr('h03, 'h000010); pull(0); fend(1);
    send('hC7, 0); fend(1); wait_idle();
    hdr('h03, 'h000010); pull(0); fend(1);

    tag = "R9"; send('hB9, 0); fend(0);
    send('hB9, 0); fend(1);
    hdr('h03, 'h000000); repeat (4) @(negedge clk); fend(1);
    hdr('h02, 'h000000); send('h44, 4); fend(1);
    send('hC7, 0); fend(1);

    tag = "R10"; send('hAB, 0); fend(0);
    hdr('hAB, 'h000000); pull(0); pull(2); pull(0); fend(1);
    send('hB9, 0); fend(1);
    hdr('hAB, 'h123456); pull(0); fend(1);
    hdr('h03, 'h000000); pull(0); fend(1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule